// File: doc/BRIEF.md
# Virtual-Output-Queue Crossbar Scheduler

This block is the central arbiter of an N-by-N input-queued crossbar. Every input port keeps a separate cell count for each output. A cell waiting for a busy output therefore never holds back cells that the same input has for other outputs. Cell arrivals are reported as a valid bit and a destination index per input. The block keeps one occupancy counter per input/output pair, and a non-zero counter is a request.

On every cycle where `slot_tick` is high, the block computes a conflict-free bipartite matching between inputs and outputs. The matching runs a fixed number of request-grant-accept rounds, unrolled in logic. Each output offers itself to one requesting input, chosen round-robin from its grant pointer. Each input then takes one offer, chosen round-robin from its accept pointer. Later rounds fill in the pairs that are still unmatched.

The result is registered into a grant matrix. That matrix stays valid until the next slot boundary, and each granted pair's counter drops by one. Reset (`rst_n`, active low, asynchronous assert) is expected to be released synchronous to `clk`.

Top module: `voq_xbar_sched`

## Requirements
- R1: An arrival on input i with destination d (field `arr_dst[i*PW +: PW]`) raises counter (i,d) by one. If that counter already holds its maximum 2^CW-1, the arrival is discarded.
- R2: A grant to pair (i,j) lowers counter (i,j) by one. An accepted arrival and a grant to the same pair at the same edge leave the counter unchanged.
- R3: Pair (i,j) requests exactly when its counter is non-zero. No grant is ever issued to a pair whose counter was zero at the slot edge.
- R4: In the grant matrix (bit i*N+j means input i is sent to output j), every row and every column has at most one bit set.
- R5: When ITER >= N the matching is maximal. No input that has a non-empty counter to some output is left unmatched while that output is also unmatched.
- R6: In each round, an unmatched output offers to the first input that requests it and is still unmatched, scanning upward with wrap from the output's grant pointer. An unmatched input accepts the first offering output, scanning upward with wrap from its accept pointer.
- R7: Pointers move only for pairs accepted in the first round. The output's grant pointer goes to one past the input, and the input's accept pointer goes to one past the output, both modulo N. All other pointers hold.
- R8: The grant matrix, pointers and counters are zero after reset. The grant matrix and pointers change only at a `slot_tick` edge, and the grant matrix holds its value between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | Slot boundary: compute and load a new matching |
| arr_vld | input | N | Per-input cell arrival strobe |
| arr_dst | input | N*PW | Per-input destination index, PW bits each |
| gnt | output | N*N | Registered grant matrix, bit i*N+j = input i to output j |

## Verification
The bench targets counter saturation. A design that wraps a full counter would hand out one grant instead of the maximum count. The bench also drives an arrival in the same cycle as a grant to that pair. Getting the net counter change wrong would add or lose a cell there, and the pair would be granted a different number of times.

Hotspot traffic, where every input targets one output, tests the column exclusion. Full-mesh and pseudo-random loads are compared slot by slot against an arithmetic model of the rounds and pointers. A pointer that moves on a later round, or lands on the partner rather than one past it, breaks the expected rotation within a few slots. A matcher run with too few rounds leaves a free input/output pair idle.

// File: rtl/vxs_pkg.sv
package vxs_pkg;

  // Next index around a ring of n positions.
  function automatic int vxs_wrap_inc(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/vxs_rr_pick.sv
// Round-robin selector: one-hot of the first set bit at or above ptr, with wrap.
module vxs_rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  vec,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  sel
);

  always_comb begin
    int idx;
    sel = '0;
    for (int off = 0; off < N; off++) begin
      idx = (int'(ptr) + off) % N;
      if (sel == '0 && vec[idx]) sel[idx] = 1'b1;
    end
  end

endmodule

// File: rtl/vxs_voq_bank.sv
// One saturating occupancy counter per input/output pair.
module vxs_voq_bank #(
  parameter int N  = 4,
  parameter int CW = 4,
  parameter int PW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    arr_vld,
  input  logic [N*PW-1:0] arr_dst,
  input  logic [N*N-1:0]  take,
  output logic [N*N-1:0]  req
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < N*N; v++) begin : g_voq
    localparam int SRC = v / N;
    localparam int DST = v % N;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit, inc, dec;

    always_comb begin
      hit   = arr_vld[SRC] && (arr_dst[SRC*PW +: PW] == PW'(DST));
      inc   = hit && (cnt_q != CNT_MAX);
      dec   = take[v];
      cnt_d = cnt_q;
      if (inc && !dec)      cnt_d = cnt_q + 1'b1;
      else if (dec && !inc) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (inc ^ dec) cnt_q <= cnt_d;
    end

    assign req[v] = |cnt_q;
  end

endmodule

// File: rtl/vxs_match.sv
// Unrolled request-grant-accept matcher, ITER rounds.
module vxs_match #(
  parameter int N    = 4,
  parameter int ITER = 4,
  parameter int PW   = 2
) (
  input  logic [N*N-1:0]  req,
  input  logic [N*PW-1:0] gptr,
  input  logic [N*PW-1:0] aptr,
  output logic [N*N-1:0]  match,
  output logic [N*N-1:0]  first
);

  logic [N-1:0]   in_m  [ITER+1];
  logic [N-1:0]   out_m [ITER+1];
  logic [N*N-1:0] stage [ITER];

  assign in_m[0]  = '0;
  assign out_m[0] = '0;

  for (genvar k = 0; k < ITER; k++) begin : g_it
    logic [N-1:0]   cand  [N];
    logic [N-1:0]   gsel  [N];
    logic [N-1:0]   offer [N];
    logic [N-1:0]   asel  [N];
    logic [N-1:0]   took_in, took_out;
    logic [N*N-1:0] mk;

    always_comb begin
      for (int j = 0; j < N; j++)
        for (int i = 0; i < N; i++)
          cand[j][i] = req[i*N+j] & ~in_m[k][i] & ~out_m[k][j];
    end

    for (genvar j = 0; j < N; j++) begin : g_out
      vxs_rr_pick #(.N(N), .PW(PW)) u_gnt (
        .vec(cand[j]), .ptr(gptr[j*PW +: PW]), .sel(gsel[j])
      );
    end

    always_comb begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          offer[i][j] = gsel[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_in
      vxs_rr_pick #(.N(N), .PW(PW)) u_acc (
        .vec(offer[i]), .ptr(aptr[i*PW +: PW]), .sel(asel[i])
      );
    end

    always_comb begin
      took_in  = '0;
      took_out = '0;
      mk       = '0;
      for (int i = 0; i < N; i++) begin
        took_in[i]  = |asel[i];
        took_out    = took_out | asel[i];
        mk[i*N +: N] = asel[i];
      end
    end

    assign in_m[k+1]  = in_m[k]  | took_in;
    assign out_m[k+1] = out_m[k] | took_out;
    assign stage[k]   = mk;
  end

  always_comb begin
    match = '0;
    for (int k = 0; k < ITER; k++) match = match | stage[k];
  end

  assign first = stage[0];

endmodule

// File: rtl/voq_xbar_sched.sv
module voq_xbar_sched
  import vxs_pkg::*;
#(
  parameter int N    = 4,
  parameter int CW   = 4,
  parameter int ITER = 4,
  localparam int PW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_tick,
  input  logic [N-1:0]    arr_vld,
  input  logic [N*PW-1:0] arr_dst,
  output logic [N*N-1:0]  gnt
);

  logic [N*N-1:0]  req_w, match_w, first_w, take_w;
  logic [N*PW-1:0] gptr_q, gptr_d, aptr_q, aptr_d;

  assign take_w = slot_tick ? match_w : '0;

  vxs_voq_bank #(.N(N), .CW(CW), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_dst(arr_dst),
    .take(take_w), .req(req_w)
  );

  vxs_match #(.N(N), .ITER(ITER), .PW(PW)) u_match (
    .req(req_w), .gptr(gptr_q), .aptr(aptr_q),
    .match(match_w), .first(first_w)
  );

  // Pointer next state: only first-round accepts move a pointer.
  always_comb begin
    gptr_d = gptr_q;
    aptr_d = aptr_q;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (first_w[i*N+j]) begin
          aptr_d[i*PW +: PW] = PW'(vxs_wrap_inc(j, N));
          gptr_d[j*PW +: PW] = PW'(vxs_wrap_inc(i, N));
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt    <= '0;
      gptr_q <= '0;
      aptr_q <= '0;
    end else if (slot_tick) begin
      gnt    <= match_w;
      gptr_q <= gptr_d;
      aptr_q <= aptr_d;
    end
  end

endmodule

// File: rtl/vxs_chk.sv
module vxs_chk #(
  parameter int N    = 4,
  parameter int ITER = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           slot_tick,
  input logic [N*N-1:0] req,
  input logic [N*N-1:0] gnt
);

  logic [N*N-1:0] req_q, free;
  logic [N-1:0]   col [N];
  logic [N-1:0]   row_used, col_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  always_comb begin
    row_used = '0;
    col_used = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        col[j][i] = gnt[i*N+j];
        if (gnt[i*N+j]) begin
          row_used[i] = 1'b1;
          col_used[j] = 1'b1;
        end
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        free[i*N+j] = !row_used[i] && !col_used[j];
  end

  for (genvar g = 0; g < N; g++) begin : g_x
    // R4
    row_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[g*N +: N]));
    // R4
    col_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[g]));
  end

  // R8
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(gnt));

  // R3
  gnt_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> ((gnt & ~req_q) == '0));

  if (ITER >= N) begin : g_max
    // R5
    maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |=> ((req_q & free) == '0));
  end

endmodule

bind voq_xbar_sched vxs_chk #(.N(N), .ITER(ITER)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req(req_w), .gnt(gnt)
);

// File: tb/test_voq_xbar_sched.sv
module test_voq_xbar_sched;

  localparam int N    = 4;
  localparam int CW   = 3;
  localparam int ITER = 4;
  localparam int PW   = 2;
  localparam int CMAX = 7;

  logic            clk;
  logic            rst_n;
  logic            slot_tick;
  logic [N-1:0]    arr_vld;
  logic [N*PW-1:0] arr_dst;
  logic [N*N-1:0]  gnt;

  int checks = 0;
  int fails  = 0;

  int cnt_m [N][N];
  int gp [N];
  int ap [N];
  logic [N*N-1:0] exp_gnt;

  voq_xbar_sched #(.N(N), .CW(CW), .ITER(ITER)) i_voq_xbar_sched (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
    .arr_vld(arr_vld), .arr_dst(arr_dst), .gnt(gnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [N*N-1:0] act, input logic [N*N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic model of the rounds (R6) and of pointer motion (R7).
  task automatic model_match(output logic [N*N-1:0] m, output logic [N*N-1:0] m1);
    bit inm [N];
    bit outm [N];
    int offer_to [N];
    m  = '0;
    m1 = '0;
    for (int i = 0; i < N; i++) begin inm[i] = 0; outm[i] = 0; end
    for (int k = 0; k < ITER; k++) begin
      for (int j = 0; j < N; j++) begin
        offer_to[j] = -1;
        if (!outm[j])
          for (int off = 0; off < N; off++) begin
            int i;
            i = (gp[j] + off) % N;
            if (offer_to[j] < 0 && !inm[i] && cnt_m[i][j] > 0) offer_to[j] = i;
          end
      end
      for (int i = 0; i < N; i++) begin
        bit done;
        done = 0;
        if (!inm[i])
          for (int off = 0; off < N; off++) begin
            int j;
            j = (ap[i] + off) % N;
            if (!done && offer_to[j] == i) begin
              done = 1;
              m[i*N+j] = 1'b1;
              if (k == 0) m1[i*N+j] = 1'b1;
            end
          end
        if (done) inm[i] = 1;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (m[i*N+j]) outm[j] = 1;
    end
  endtask

  task automatic step(input bit tick, input logic [N-1:0] av, input logic [N*PW-1:0] ad);
    logic [N*N-1:0] em, em1, prq, fr;
    int newc [N][N];
    bit ok;
    int rc, cc;
    slot_tick = tick;
    arr_vld   = av;
    arr_dst   = ad;
    prq = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (cnt_m[i][j] > 0) prq[i*N+j] = 1'b1;
    em = '0; em1 = '0;
    if (tick) model_match(em, em1);
    @(posedge clk);
    newc = cnt_m;
    for (int i = 0; i < N; i++)
      if (av[i]) begin
        int d;
        d = int'(ad[i*PW +: PW]);
        if (cnt_m[i][d] < CMAX) newc[i][d]++;   // R1 saturation rule
      end
    if (tick) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (em[i*N+j]) newc[i][j]--;           // R2
          if (em1[i*N+j]) begin
            ap[i] = (j + 1) % N;
            gp[j] = (i + 1) % N;
          end
        end
      exp_gnt = em;
    end
    cnt_m = newc;
    @(negedge clk);
    slot_tick = 1'b0;
    arr_vld   = '0;
    if (tick) begin
      chk(gnt === exp_gnt, "R6 R7 matching vs model", gnt, exp_gnt);
      chk((gnt & ~prq) == '0, "R3 grant only to non-empty", gnt, gnt & prq);
      ok = 1;
      for (int g = 0; g < N; g++) begin
        rc = 0; cc = 0;
        for (int h = 0; h < N; h++) begin
          rc += int'(gnt[g*N+h]);
          cc += int'(gnt[h*N+g]);
        end
        if (rc > 1 || cc > 1) ok = 0;
      end
      chk(ok, "R4 row/column exclusion", gnt, exp_gnt);
      fr = '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          bit rf, cf;
          rf = (gnt[i*N +: N] == '0);
          cf = 1;
          for (int h = 0; h < N; h++) if (gnt[h*N+j]) cf = 0;
          fr[i*N+j] = rf && cf;
        end
      chk((prq & fr) == '0, "R5 maximal matching", prq & fr, '0);
    end else begin
      chk(gnt === exp_gnt, "R8 grants held between ticks", gnt, exp_gnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int sat_hits;
    rst_n     = 1'b0;
    slot_tick = 1'b0;
    arr_vld   = '0;
    arr_dst   = '0;
    exp_gnt   = '0;
    for (int i = 0; i < N; i++) begin
      gp[i] = 0; ap[i] = 0;
      for (int j = 0; j < N; j++) cnt_m[i][j] = 0;
    end
    repeat (3) @(negedge clk);
    chk(gnt === '0, "R8 reset clears grants", gnt, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Empty queues: no grant (R3)
    step(1, '0, '0);

    // Full mesh: each input loads one cell for every output
    for (int c = 0; c < N; c++)
      step(0, 4'hF, {PW'(c), PW'(c), PW'(c), PW'(c)});
    for (int s = 0; s < 6; s++) step(1, '0, '0);

    // Hotspot: every input targets output 0
    for (int s = 0; s < 12; s++) step(1, 4'hF, '0);
    for (int s = 0; s < 40; s++) step(1, '0, '0);

    // R1 saturation: 9 arrivals to pair (0,0), then count grants
    for (int s = 0; s < 9; s++) step(0, 4'b0001, '0);
    sat_hits = 0;
    for (int s = 0; s < 10; s++) begin
      step(1, '0, '0);
      if (gnt[0]) sat_hits++;
    end
    chk(sat_hits == CMAX, "R1 saturated counter yields max grants",
        16'(sat_hits), 16'(CMAX));

    // R2: arrival and grant to the same pair at one edge
    step(0, 4'b0010, 8'b0000_1000);                 // input 1 -> output 2
    step(1, 4'b0010, 8'b0000_1000);
    chk(gnt === 16'h0040, "R2 grant with simultaneous arrival", gnt, 16'h0040);
    step(1, '0, '0);
    chk(gnt === 16'h0040, "R2 counter kept its cell", gnt, 16'h0040);
    step(1, '0, '0);
    chk(gnt === '0, "R2 R3 counter now empty", gnt, '0);

    // Hold between ticks with traffic arriving (R8)
    step(0, 4'b0001, 8'h03);
    step(1, '0, '0);
    for (int s = 0; s < 3; s++) step(0, 4'b1100, 8'hA0);

    // Pseudo-random sweep
    lfsr = 16'hACE1;
    for (int s = 0; s < 600; s++) begin
      logic [N-1:0]    av;
      logic [N*PW-1:0] ad;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      av   = lfsr[3:0];
      ad   = lfsr[15:8];
      step((s % 3) != 2, av, ad);
    end
    for (int s = 0; s < 40; s++) step(1, '0, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule